// File: doc/BRIEF.md
# ADC Control Register Interface

This block is the register front end of a decimating converter. A host sends 16-bit words on a single write strobe. Outside a coefficient download, words alternate between an address word and a data word for that address. The block holds two control registers and three 16-bit calibration registers (gain, offset, overrange threshold). From these it produces the decoded decimation ratio, the FIR enable and length, a one-cycle synchronization pulse and three power controls.

Command bits in the first control register take effect once and are not kept. A read-select command makes the next host read return a chosen register instead of the conversion result; the read strobe consumes that selection. A download command puts the write path into a counted sequence. The sequence takes a number of coefficient words set by the filter-length field, each sent out as a coefficient write strobe, and then one checksum word. The checksum result is recorded in a status word.

Top module: `adc_regfront`

## Requirements
- R1: A write is an address word followed by a data word, each on a cycle with `wr_valid` high. Control 1 is at address 0x0001, control 2 at 0x0002, gain at 0x0003, offset at 0x0004 and overrange threshold at 0x0005. Each register takes the data word at the clock edge that captures it.
- R2: After reset, control 1 holds 0x001A and control 2 holds 0x009B. So `dec_ratio`=4, `fir_en`=1, `filt_len`=0, `pwr_down`=1, `low_power`=0 and `amp_down`=1.
- R3: `dec_ratio` carries the ratio as a plain number and is decoded from control 1 bits 2:0. Codes 0, 1 and 2 give 4, code 3 gives 8, code 4 gives 16, and codes 5, 6 and 7 give 32.
- R4: `fir_en` follows control 1 bit 4, where 0 means the FIR is bypassed. `filt_len` follows control 1 bits 8:5.
- R5: `pwr_down` follows control 2 bit 3, `low_power` follows bit 2 and `amp_down` follows bit 0.
- R6: A control 1 write with bit 9 set raises `sync_pulse` for exactly one cycle after the capturing edge. The bit is not retained.
- R7: Control 1 bits 14, 13, 12 and 11 select the overrange threshold, gain, offset and status registers. A control 1 write with exactly one of them set makes `rd_data` show that register and sets `rd_is_reg`. This lasts until a cycle with `rd_req` high, after which `rd_data` returns `conv_data`. A control 1 write with none of them set also returns reads to `conv_data`.
- R8: A control 1 write with more than one read-select bit set selects nothing: `rd_data` shows `conv_data` and `rd_is_reg` is 0.
- R9: When `rd_req` falls in the same cycle as a control 1 data write, that read returns the source chosen before the write, and the new selection holds from the next cycle on.
- R10: A control 1 write with bit 15 set starts a download. Bits 8:5 of the same word (L) fix the count at (L+1)*2 coefficient words. Every following word is a coefficient, with no address phase. For each one, `coef_we` is high in the cycle of the word, `coef_addr` counts from 0 and `coef_data` equals the word. `dl_busy` stays high until the checksum word.
- R11: The word after the last coefficient is the checksum. It is compared with the wrapping 16-bit sum of the coefficients and does not raise `coef_we`. The status word is {13'b0, error, done, busy}. A match sets done, and a mismatch sets error, which stays set until reset. Starting a download clears done. Afterwards the next word is an address again.
- R12: A write to any address other than the five above changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host word strobe |
| wr_word | input | 16 | Host address, data, coefficient or checksum word |
| rd_req | input | 1 | Host read strobe; consumes a pending read selection |
| conv_data | input | 16 | Conversion result from the filter chain |
| rd_data | output | 16 | Selected register or conversion result |
| rd_is_reg | output | 1 | High while a register is selected for reading |
| dec_ratio | output | 6 | Decimation ratio: 4, 8, 16 or 32 |
| fir_en | output | 1 | Programmable FIR enabled |
| filt_len | output | 4 | Filter-length field |
| sync_pulse | output | 1 | One-cycle synchronization request |
| pwr_down | output | 1 | Converter power-down |
| low_power | output | 1 | Low-power mode |
| amp_down | output | 1 | Differential amplifier power-down |
| coef_we | output | 1 | Coefficient write strobe |
| coef_addr | output | 6 | Coefficient index |
| coef_data | output | 16 | Coefficient value |
| dl_busy | output | 1 | Download in progress |

## Verification
The read strobe and a control 1 data write can fall in the same cycle. One ends the pending selection and the other installs a new one. The bench first selects gain. It then drives `rd_req` in the same cycle as the data word that selects offset. The read in that cycle must return the gain value, and the offset value must follow in the next cycle. A second point of contact is a download entered from a write that also carries read-select bits. Here the following words must be taken as coefficients while the selection still applies to reads.

// File: rtl/adc_regfront.sv
module adc_regfront #(
  parameter int LEN_UNIT = 2,
  parameter logic [15:0] A_CTRL1 = 16'h0001,
  parameter logic [15:0] A_CTRL2 = 16'h0002,
  parameter logic [15:0] A_GAIN  = 16'h0003,
  parameter logic [15:0] A_OFFS  = 16'h0004,
  parameter logic [15:0] A_OVR   = 16'h0005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  input  logic [15:0] wr_word,
  input  logic        rd_req,
  input  logic [15:0] conv_data,
  output logic [15:0] rd_data,
  output logic        rd_is_reg,
  output logic [5:0]  dec_ratio,
  output logic        fir_en,
  output logic [3:0]  filt_len,
  output logic        sync_pulse,
  output logic        pwr_down,
  output logic        low_power,
  output logic        amp_down,
  output logic        coef_we,
  output logic [$clog2(16*LEN_UNIT+1)-1:0] coef_addr,
  output logic [15:0] coef_data,
  output logic        dl_busy
);
  localparam int CW = $clog2(16*LEN_UNIT+1);

  logic        phase;
  logic [15:0] addr_q;
  logic [8:0]  ctrl1_q;
  logic [15:0] ctrl2_q, gain_q, offs_q, ovr_q;
  logic [1:0]  sel_q;
  logic        sel_v, dl_done, cks_err;
  logic [CW-1:0] cnt, total;
  logic [15:0] sum, status;
  logic        data_wr, wr_c1, sel_one;
  logic [1:0]  sel_code;

  assign data_wr = wr_valid && phase && !dl_busy;
  assign wr_c1   = data_wr && (addr_q == A_CTRL1);
  assign total   = CW'((32'(ctrl1_q[8:5]) + 32'd1) * LEN_UNIT);
  assign status  = {13'b0, cks_err, dl_done, dl_busy};

  always_comb begin
    sel_one  = 1'b1;
    sel_code = 2'd0;
    case (wr_word[14:11])
      4'b1000: sel_code = 2'd0;
      4'b0100: sel_code = 2'd1;
      4'b0010: sel_code = 2'd2;
      4'b0001: sel_code = 2'd3;
      default: sel_one = 1'b0;
    endcase
  end

  always_comb begin
    case (ctrl1_q[2:0])
      3'd3:         dec_ratio = 6'd8;
      3'd4:         dec_ratio = 6'd16;
      3'd5, 3'd6, 3'd7: dec_ratio = 6'd32;
      default:      dec_ratio = 6'd4;
    endcase
  end

  always_comb begin
    rd_data = conv_data;
    if (sel_v)
      case (sel_q)
        2'd0: rd_data = ovr_q;
        2'd1: rd_data = gain_q;
        2'd2: rd_data = offs_q;
        default: rd_data = status;
      endcase
  end

  assign rd_is_reg = sel_v;
  assign fir_en    = ctrl1_q[4];
  assign filt_len  = ctrl1_q[8:5];
  assign pwr_down  = ctrl2_q[3];
  assign low_power = ctrl2_q[2];
  assign amp_down  = ctrl2_q[0];
  assign coef_we   = dl_busy && wr_valid && (cnt != total);
  assign coef_addr = cnt;
  assign coef_data = wr_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;  addr_q <= '0;
      ctrl1_q <= 9'h01A;  ctrl2_q <= 16'h009B;
      gain_q <= 16'h8000;  offs_q <= '0;  ovr_q <= 16'hFFFF;
      sel_q <= '0;  sel_v <= 1'b0;  sync_pulse <= 1'b0;
      dl_busy <= 1'b0;  dl_done <= 1'b0;  cks_err <= 1'b0;
      cnt <= '0;  sum <= '0;
    end else begin
      sync_pulse <= wr_c1 && wr_word[9];
      if (wr_valid && !dl_busy) begin
        phase <= ~phase;
        if (!phase) addr_q <= wr_word;
      end
      if (rd_req) sel_v <= 1'b0;
      if (wr_c1) begin
        ctrl1_q <= wr_word[8:0];
        sel_v   <= sel_one;
        sel_q   <= sel_code;
        if (wr_word[15]) begin
          dl_busy <= 1'b1;  dl_done <= 1'b0;
          cnt <= '0;  sum <= '0;
        end
      end
      if (data_wr && addr_q == A_CTRL2) ctrl2_q <= wr_word;
      if (data_wr && addr_q == A_GAIN)  gain_q  <= wr_word;
      if (data_wr && addr_q == A_OFFS)  offs_q  <= wr_word;
      if (data_wr && addr_q == A_OVR)   ovr_q   <= wr_word;
      if (dl_busy && wr_valid) begin
        if (cnt != total) begin
          cnt <= cnt + 1'b1;
          sum <= sum + wr_word;
        end else begin
          dl_busy <= 1'b0;
          if (wr_word == sum) dl_done <= 1'b1;
          else cks_err <= 1'b1;
        end
      end
    end
  end
endmodule

module adc_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        wr_valid,
  input logic        phase,
  input logic [15:0] addr_q,
  input logic        rd_is_reg,
  input logic [5:0]  dec_ratio,
  input logic        sync_pulse,
  input logic        coef_we,
  input logic        dl_busy,
  input logic        cks_err,
  input logic [15:0] gain_q
);
  logic c1_data, gain_data;
  assign c1_data   = wr_valid && phase && !dl_busy && addr_q == 16'h0001;
  assign gain_data = wr_valid && phase && !dl_busy && addr_q == 16'h0003;

  // R3
  dec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dec_ratio) == 1 && dec_ratio[1:0] == 2'b00);
  // R6
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
  // R10
  coef_in_dl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |-> dl_busy);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cks_err |=> cks_err);
  // R7
  read_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !c1_data |=> !rd_is_reg);
  // R12
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_data |=> $stable(gain_q));
endmodule

bind adc_regfront adc_regfront_chk chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_valid(wr_valid),
  .phase(phase), .addr_q(addr_q), .rd_is_reg(rd_is_reg),
  .dec_ratio(dec_ratio), .sync_pulse(sync_pulse), .coef_we(coef_we),
  .dl_busy(dl_busy), .cks_err(cks_err), .gain_q(gain_q)
);

// File: tb/tb_adc_regfront.sv
module tb_adc_regfront;
  logic clk = 1'b0, rst_n = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [15:0] wr_word = '0, conv_data = 16'hC0DE;
  logic [15:0] rd_data, coef_data;
  logic rd_is_reg, fir_en, sync_pulse, pwr_down, low_power, amp_down, coef_we, dl_busy;
  logic [5:0] dec_ratio, coef_addr;
  logic [3:0] filt_len;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  adc_regfront dut (.*);

  // {addr, data, dec_ratio, fir_en, filt_len, pwr_down, low_power, amp_down}
  localparam int NV = 11;
  localparam logic [45:0] VEC [NV] = '{
    {16'h0001, 16'h0013, 6'd8,  1'b1, 4'd0,  3'b101},
    {16'h0001, 16'h000C, 6'd16, 1'b0, 4'd0,  3'b101},
    {16'h0001, 16'h001D, 6'd32, 1'b1, 4'd0,  3'b101},
    {16'h0001, 16'h000E, 6'd32, 1'b0, 4'd0,  3'b101},
    {16'h0001, 16'h001F, 6'd32, 1'b1, 4'd0,  3'b101},
    {16'h0001, 16'h01F4, 6'd16, 1'b1, 4'd15, 3'b101},
    {16'h0001, 16'h0009, 6'd4,  1'b0, 4'd0,  3'b101},
    {16'h0002, 16'h0006, 6'd4,  1'b0, 4'd0,  3'b010},
    {16'h0002, 16'h000B, 6'd4,  1'b0, 4'd0,  3'b101},
    {16'h0007, 16'h0000, 6'd4,  1'b0, 4'd0,  3'b101},
    {16'h0001, 16'h001A, 6'd4,  1'b1, 4'd0,  3'b101}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic wreg(input logic [15:0] a, input logic [15:0] d);
    put(a); put(d);
  endtask

  task automatic rd_pulse(input string req, input logic [15:0] exp);
    @(negedge clk); rd_req = 1'b1; #1 chk(req, rd_data, exp);
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic coef(input logic [5:0] idx, input logic [15:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    #1 chk("R10 coef_we", coef_we, 1);
    chk("R10 coef_addr", coef_addr, idx);
    chk("R10 coef_data", coef_data, w);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic cksum(input logic [15:0] w);
    @(negedge clk); wr_valid = 1'b1; wr_word = w;
    #1 chk("R11 no strobe on checksum", coef_we, 0);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 dec_ratio", dec_ratio, 4);
    chk("R2 fir_en", fir_en, 1);
    chk("R2 filt_len", filt_len, 0);
    chk("R2 power", {pwr_down, low_power, amp_down}, 3'b101);
    chk("R7 reset read", rd_data, 16'hC0DE);
    chk("R7 reset rd_is_reg", rd_is_reg, 0);

    // R1 R3 R4 R5 R12 table walk
    for (int i = 0; i < NV; i++) begin
      wreg(VEC[i][45:30], VEC[i][29:14]);
      chk("R3 dec_ratio", dec_ratio, VEC[i][13:8]);
      chk("R4 fir_en", fir_en, VEC[i][7]);
      chk("R4 filt_len", filt_len, VEC[i][6:3]);
      chk("R5 power", {pwr_down, low_power, amp_down}, VEC[i][2:0]);
    end

    // R1 calibration registers, read back through R7 selection
    wreg(16'h0003, 16'h1234);
    wreg(16'h0004, 16'h0ABC);
    wreg(16'h0005, 16'h7F00);
    wreg(16'h0009, 16'hBEEF);  // R12 unmapped
    wreg(16'h0001, 16'h2018);
    chk("R7 gain selected", rd_is_reg, 1);
    rd_pulse("R12 gain kept after unmapped write", 16'h1234);
    chk("R7 selection consumed", rd_data, 16'hC0DE);
    chk("R7 rd_is_reg cleared", rd_is_reg, 0);
    wreg(16'h0001, 16'h4018);
    rd_pulse("R7 overrange read", 16'h7F00);
    wreg(16'h0001, 16'h1018);
    rd_pulse("R7 offset read", 16'h0ABC);
    wreg(16'h0001, 16'h0818);
    rd_pulse("R7 status read", 16'h0000);
    wreg(16'h0001, 16'h2018);
    wreg(16'h0001, 16'h0018);
    chk("R7 write without select", rd_is_reg, 0);

    // R8 multiple select bits
    wreg(16'h0001, 16'h6018);
    chk("R8 rejected rd_is_reg", rd_is_reg, 0);
    chk("R8 rejected rd_data", rd_data, 16'hC0DE);

    // R9 read coinciding with control write
    wreg(16'h0001, 16'h2018);
    put(16'h0001);
    @(negedge clk); wr_valid = 1'b1; wr_word = 16'h1018; rd_req = 1'b1;
    #1 chk("R9 same-cycle read uses old source", rd_data, 16'h1234);
    @(negedge clk); wr_valid = 1'b0; rd_req = 1'b0;
    chk("R9 new selection after", rd_data, 16'h0ABC);
    chk("R9 rd_is_reg after", rd_is_reg, 1);
    rd_pulse("R9 offset consumed", 16'h0ABC);

    // R6 sync pulse
    wreg(16'h0001, 16'h0218);
    chk("R6 sync high", sync_pulse, 1);
    @(negedge clk);
    chk("R6 sync one cycle", sync_pulse, 0);

    // R10 R11 download, L=1 -> 4 coefficients
    wreg(16'h0001, 16'h8038);
    chk("R10 busy", dl_busy, 1);
    coef(6'd0, 16'h1111);
    coef(6'd1, 16'h2222);
    coef(6'd2, 16'h0001);  // would be an address outside download
    chk("R10 address word not decoded", dec_ratio, 4);
    coef(6'd3, 16'h3333);
    chk("R10 still busy before checksum", dl_busy, 1);
    cksum(16'h6667);
    chk("R11 busy cleared", dl_busy, 0);
    wreg(16'h0001, 16'h0818);
    rd_pulse("R11 status done", 16'h0002);

    // R11 wrong checksum, L=0 -> 2 coefficients, wrap-around sum 0x0001
    wreg(16'h0001, 16'h8018);
    coef(6'd0, 16'hFFFF);
    coef(6'd1, 16'h0002);
    cksum(16'h0005);
    wreg(16'h0001, 16'h0818);
    rd_pulse("R11 status error", 16'h0004);

    // R11 error sticky through a good download
    wreg(16'h0001, 16'h8018);
    coef(6'd0, 16'h0001);
    coef(6'd1, 16'h0002);
    cksum(16'h0003);
    wreg(16'h0001, 16'h0818);
    rd_pulse("R11 sticky error with done", 16'h0006);

    // R1 address phase restored after download
    wreg(16'h0001, 16'h001B);
    chk("R1 write after download", dec_ratio, 8);

    finish_run();
  end
endmodule